// File: doc/BRIEF.md
# Input capture event generator

This block watches an external pin that is not timed to the internal clock and produces a capture strobe one clock cycle wide. When the strobe fires, the block stores the current value of one of two 16-bit free-running timer inputs. A 3-bit mode field chooses when the strobe fires:

- on falling edges only;
- on rising edges only;
- on both edges;
- on every 4th rising edge;
- on every 16th rising edge;
- never, when the unit is off.

The prescaled modes make one captured interval cover several input periods. Averaging over those periods gives a measure of the mean input rate.

The pin passes through a two-flop synchronizer. An edge detector then looks at the synchronized level, so the latency from a pin change to the strobe is fixed. In the prescaled modes a prescale counter counts the rising edges that qualify. Only the off encodings and reset clear this counter. Because of that, moving from one active mode straight to another keeps the count already reached, and this can make the next capture come early. The outputs are the strobe, the captured timer word and a flag that marks strobes from the both-edges mode.

Top module: `capture_event_gen`

## Requirements
- R1: Synchronous active-high reset drives `cap_strobe`, `cap_both_edge` and `cap_value` to 0 and clears the prescale count. After reset, mode 3'b100 needs four new rising edges before its first strobe.
- R2: The pin is sampled on a rising clock edge. The strobe caused by that change is high for exactly one cycle, starting at the second clock edge after the sampling edge. It is low at the first edge after the sampling edge, and it is low again one cycle later.
- R3: Modes 3'b000, 3'b110 and 3'b111 produce no strobe on any edge, and they clear the prescale count.
- R4: Mode 3'b001 fires on every rising edge and on every falling edge of the pin.
- R5: Mode 3'b010 fires on every falling edge only. Mode 3'b011 fires on every rising edge only.
- R6: Mode 3'b100 fires on every 4th rising edge and mode 3'b101 on every 16th rising edge. Falling edges do not affect the count.
- R7: The prescale count increments only on rising edges seen in modes 3'b100 and 3'b101. It holds in modes 3'b001 to 3'b011 and when changing directly between active modes. A rising edge fires and resets the count to 0 when the count already stands at or above the terminal value (3 in mode 3'b100, 15 in mode 3'b101). A residual count can therefore fire early.
- R8: On a strobe, `cap_value` takes `timer_a` when `tmr_sel` is 1 and `timer_b` when it is 0. The value stored is the one present in the cycle before the strobe is registered.
- R9: `cap_value` changes only together with a strobe. Between strobes it holds the last captured word.
- R10: `cap_both_edge` is high only together with a strobe that mode 3'b001 produced, and it is low with strobes from every other mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 1 | External pin, not timed to the clock |
| mode | input | 3 | Capture mode selection |
| tmr_sel | input | 1 | 1 selects timer_a, 0 selects timer_b |
| timer_a | input | 16 | First timer value |
| timer_b | input | 16 | Second timer value |
| cap_strobe | output | 1 | One-cycle capture strobe |
| cap_value | output | 16 | Last captured timer word |
| cap_both_edge | output | 1 | Strobe came from the both-edges mode |

## Verification
Each of the eight mode encodings is tried with both timer selections. For each combination the pin toggles forty times and the timer values change at every change of the pin. This alternating pattern separates falling-edge, rising-edge and both-edge qualification. It also catches a prescale terminal that is off by one, and it shows which timer was latched and in which cycle.

Further sequences test the residual count:
- going directly from divide-by-16 to divide-by-4 after six rising edges, which must give an early capture;
- going from divide-by-4 to divide-by-16;
- passing through off, which must clear the count.

A reset applied in the middle of a count checks that reset clears the prescaler as well as the outputs.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    CM_OFF   = 3'b000,
    CM_BOTH  = 3'b001,
    CM_FALL  = 3'b010,
    CM_RISE  = 3'b011,
    CM_DIV4  = 3'b100,
    CM_DIV16 = 3'b101,
    CM_RSV6  = 3'b110,
    CM_RSV7  = 3'b111
  } cap_mode_e;

  function automatic logic mode_is_off(input cap_mode_e m);
    return (m == CM_OFF) || (m == CM_RSV6) || (m == CM_RSV7);
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int SHORT_DIV = 4,
  parameter int LONG_DIV  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic long_sel,
  output logic hit
);
  localparam int CW = $clog2(LONG_DIV);
  localparam logic [CW-1:0] SHORT_TERM = CW'(SHORT_DIV - 1);
  localparam logic [CW-1:0] LONG_TERM  = CW'(LONG_DIV - 1);

  logic [CW-1:0] count;
  logic [CW-1:0] term;

  assign term = long_sel ? LONG_TERM : SHORT_TERM;
  assign hit  = step && (count >= term);

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (hit)    count <= '0;
    else if (step)   count <= count + 1'b1;
  end
endmodule

// File: rtl/capture_event_gen.sv
module capture_event_gen
  import cap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_DIV   = 4,
  parameter int LONG_DIV    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_async,
  input  logic [2:0]    mode,
  input  logic          tmr_sel,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  output logic          cap_strobe,
  output logic [TW-1:0] cap_value,
  output logic          cap_both_edge
);
  cap_mode_e m;
  logic pin_s, rise, fall, ps_step, ps_hit, off, fire;

  assign m = cap_mode_e'(mode);

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_async), .dout(pin_s)
  );

  cap_edge_det u_edge (
    .clk(clk), .rst(rst), .level(pin_s), .rise(rise), .fall(fall)
  );

  assign off     = mode_is_off(m);
  assign ps_step = rise && ((m == CM_DIV4) || (m == CM_DIV16));

  cap_prescaler #(.SHORT_DIV(SHORT_DIV), .LONG_DIV(LONG_DIV)) u_ps (
    .clk(clk), .rst(rst), .clr(off), .step(ps_step),
    .long_sel(m == CM_DIV16), .hit(ps_hit)
  );

  always_comb begin
    unique case (m)
      CM_BOTH:           fire = rise | fall;
      CM_FALL:           fire = fall;
      CM_RISE:           fire = rise;
      CM_DIV4, CM_DIV16: fire = ps_hit;
      default:           fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_strobe    <= 1'b0;
      cap_both_edge <= 1'b0;
      cap_value     <= '0;
    end else begin
      cap_strobe    <= fire;
      cap_both_edge <= fire && (m == CM_BOTH);
      if (fire) cap_value <= tmr_sel ? timer_a : timer_b;
    end
  end
endmodule

// File: rtl/capture_event_gen_chk.sv
module capture_event_gen_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    mode,
  input logic          tmr_sel,
  input logic [TW-1:0] timer_a,
  input logic [TW-1:0] timer_b,
  input logic          cap_strobe,
  input logic [TW-1:0] cap_value,
  input logic          cap_both_edge
);
  // R3
  off_silent_chk: assert property (@(posedge clk) disable iff (rst)
    cap_strobe |-> !($past(mode) == 3'b000 || $past(mode) == 3'b110 || $past(mode) == 3'b111));

  // R8
  timer_pick_chk: assert property (@(posedge clk) disable iff (rst)
    cap_strobe |-> cap_value == $past(tmr_sel ? timer_a : timer_b));

  // R9
  value_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_value) |-> cap_strobe);

  // R10
  both_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cap_both_edge |-> cap_strobe && $past(mode) == 3'b001);
endmodule

bind capture_event_gen capture_event_gen_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .tmr_sel(tmr_sel),
  .timer_a(timer_a), .timer_b(timer_b), .cap_strobe(cap_strobe),
  .cap_value(cap_value), .cap_both_edge(cap_both_edge)
);

// File: tb/capture_event_gen_tb.sv
module capture_event_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic        tmr_sel = 1'b0;
  logic [15:0] timer_a = '0;
  logic [15:0] timer_b = '0;
  logic        cap_strobe, cap_both_edge;
  logic [15:0] cap_value;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int evn = 0;
  int exp_cnt = 0;
  logic [15:0] exp_val = '0;

  always #2 clk = ~clk;

  capture_event_gen u_dut (
    .clk(clk), .rst(rst), .pin_async(pin), .mode(mode), .tmr_sel(tmr_sel),
    .timer_a(timer_a), .timer_b(timer_b), .cap_strobe(cap_strobe),
    .cap_value(cap_value), .cap_both_edge(cap_both_edge)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'b001:         return "R4";
      3'b010, 3'b011: return "R5";
      3'b100, 3'b101: return "R6";
      default:        return "R3";
    endcase
  endfunction

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
    if (m == 3'b000 || m == 3'b110 || m == 3'b111) exp_cnt = 0;
    @(posedge clk);
  endtask

  task automatic pin_event(input string tag);
    logic rising, fire;
    int term;
    @(negedge clk);
    pin = ~pin;
    evn++;
    timer_a = 16'hA000 ^ 16'(evn * 13);
    timer_b = 16'h5000 + 16'(evn * 7);
    rising = pin;
    fire = 1'b0;
    case (mode)
      3'b001: fire = 1'b1;
      3'b010: fire = !rising;
      3'b011: fire = rising;
      3'b100, 3'b101: begin
        term = (mode == 3'b100) ? 3 : 15;
        if (rising) begin
          if (exp_cnt >= term) begin fire = 1'b1; exp_cnt = 0; end
          else exp_cnt++;
        end
      end
      default: begin fire = 1'b0; exp_cnt = 0; end
    endcase
    if (fire) exp_val = tmr_sel ? timer_a : timer_b;
    @(posedge clk);               // sampling edge
    @(posedge clk); #1;
    chk(32'(cap_strobe), 0, "R2 early");
    @(posedge clk); #1;
    chk(32'(cap_strobe), 32'(fire), tag);
    chk(32'(cap_value), 32'(exp_val), fire ? "R8 value" : "R9 hold");
    chk(32'(cap_both_edge), 32'(fire && mode == 3'b001), "R10 flag");
    @(posedge clk); #1;
    chk(32'(cap_strobe), 0, "R2 width");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(32'(cap_strobe), 0, "R1 strobe");
    chk(32'(cap_value), 0, "R1 value");
    chk(32'(cap_both_edge), 0, "R1 flag");
    @(negedge clk); rst = 1'b0;

    // sweep every mode with both timer selections
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 2; s++) begin
        tmr_sel = s[0];
        set_mode(3'(m));
        for (int t = 0; t < 40; t++) pin_event(mode_tag(3'(m)));
      end
    end

    // R7: residual from divide-by-16 into divide-by-4 fires early
    set_mode(3'b000);
    set_mode(3'b101);
    for (int t = 0; t < 12; t++) pin_event("R7 build");
    set_mode(3'b100);
    if (pin) pin_event("R7 fall");
    pin_event("R7 early");
    // R7: residual from divide-by-4 into divide-by-16, then hold in edge modes
    for (int t = 0; t < 4; t++) pin_event("R7 build4");
    set_mode(3'b011);
    for (int t = 0; t < 4; t++) pin_event("R7 hold");
    set_mode(3'b101);
    for (int t = 0; t < 34; t++) pin_event("R7 long");
    // R3: passing through off clears the residual
    for (int t = 0; t < 10; t++) pin_event("R7 pre");
    set_mode(3'b110);
    set_mode(3'b100);
    for (int t = 0; t < 12; t++) pin_event("R3 cleared");

    // R1: reset in the middle of a count
    if (pin) pin_event("R1 align");
    for (int t = 0; t < 4; t++) pin_event("R1 pre");
    @(negedge clk); rst = 1'b1;
    exp_cnt = 0; exp_val = '0;
    @(posedge clk); @(posedge clk); #1;
    chk(32'(cap_value), 0, "R1 value mid");
    chk(32'(cap_strobe), 0, "R1 strobe mid");
    @(negedge clk); rst = 1'b0;
    for (int t = 0; t < 10; t++) pin_event("R1 recount");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule